// File: doc/BRIEF.md
# Self-Invalidating Word-State Cache Controller

This block tracks the coherence state of every word in a core's private cache without relying on invalidation messages from other cores. Each word is held in one of three stable states (Invalid, Valid or Registered) with no transient states. Loads and stores arrive one at a time, each tagged with a region number and a flag that marks an access as having an atomic effect. A store takes ownership of its word at once and asks the shared cache to record this core as the owner of the current copy. A load to an Invalid word raises a read-miss request and stalls until the fill data returns.

Stale data is removed by the core itself. When a parallel phase ends, a one-cycle command carries a mask of the regions that were writeable during the phase, and every Valid word in those regions drops to Invalid in a single cycle. Inside a critical section, an atomic load to a Valid word is treated as a miss when the lock's access signature reports a possible conflict. A touched bit on each word keeps a word that has already been read atomically in the current critical section from being dropped again. A critical-section entry pulse clears all touched bits. Registered words are never dropped, because this core holds their current copy.

Top module: `sicache_word_ctrl`

## Requirements
- R1: After reset every word is Invalid, req_ready is 1 and rsp_valid, miss_valid and reg_valid are 0. The state codes are 00 Invalid, 01 Valid and 10 Registered, and the code 11 never occurs.
- R2: An accepted store writes req_wdata into the word and makes it Registered. In the next cycle rsp_valid is 1 with rsp_rdata equal to the write data. If no registration is outstanding for the word, reg_valid is also 1 for that one cycle, with reg_addr equal to the word address.
- R3: A phase_end pulse turns every Valid word whose region bit is set in phase_regions into Invalid. Valid words whose region bit is clear stay Valid.
- R4: A Registered word stays Registered and keeps its data through phase_end pulses, critical-section entries and atomic loads that see sig_hit.
- R5: A load to an Invalid word gives miss_valid = 1 for one cycle, with miss_addr equal to the address, in the cycle after acceptance. From then until fill_valid, req_ready is 0 and rsp_valid is 0. In the cycle after fill_valid, rsp_valid is 1 with rsp_rdata equal to fill_data, and the word becomes Valid with the load's region.
- R6: A load to a Valid or Registered word that is not self-invalidated gives rsp_valid = 1 and the stored data in the next cycle, with miss_valid = 0.
- R7: An atomic load to a Valid word whose touched bit is clear, and for which sig_hit is 1, discards the word and is handled as a miss (R5). A non-atomic load, or an atomic load with sig_hit = 0, to a Valid word is a hit.
- R8: An atomic load sets the word's touched bit, both on a hit and when its fill arrives. A later atomic load to a touched Valid word hits even when sig_hit is 1.
- R9: A cs_enter pulse clears every touched bit in one cycle, so the next atomic load with sig_hit to a Valid word misses again.
- R10: A store to a word whose registration is still pending issues no new registration (reg_valid stays 0). A reg_ack_valid pulse with reg_ack_addr clears the pending flag, and the next store to that word issues a registration again.
- R11: req_ready is 0 in any cycle in which phase_end or cs_enter is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_store | input | 1 | 1 = store, 0 = load |
| req_atomic | input | 1 | Access has an atomic effect |
| req_addr | input | IDX_W | Word address |
| req_region | input | REGION_W | Region of the access |
| req_wdata | input | DATA_W | Store data |
| sig_hit | input | 1 | Signature lookup result for req_addr |
| req_ready | output | 1 | Request is accepted in this cycle |
| rsp_valid | output | 1 | Completion pulse |
| rsp_rdata | output | DATA_W | Load data, or store data echoed back |
| miss_valid | output | 1 | Read-miss request pulse |
| miss_addr | output | IDX_W | Word address of the miss |
| fill_valid | input | 1 | Fill data for the outstanding miss |
| fill_data | input | DATA_W | Fill data |
| reg_valid | output | 1 | Registration request pulse |
| reg_addr | output | IDX_W | Word address to register |
| reg_ack_valid | input | 1 | Registration acknowledgement |
| reg_ack_addr | input | IDX_W | Word address of the acknowledgement |
| phase_end | input | 1 | End-of-phase self-invalidation pulse |
| phase_regions | input | 2**REGION_W | One bit per region to invalidate |
| cs_enter | input | 1 | Critical-section entry pulse |

## Verification
The bench aims at words whose state changes after an earlier access. It checks that a Registered word survives a full-mask phase end; a design that dropped it would raise a miss. It checks that the phase mask is applied per region; a design that ignored the region would miss on a neighbouring word. It checks that a touched word gives a hit on a second atomic load with sig_hit, and that cs_enter brings back the miss; a design that got either wrong would repeat or skip the refill. It also checks that a second store while a registration is pending stays silent, and that a store after the acknowledgement registers again; a wrong pending flag would show as a reg_valid pulse that is missing or one too many.

// File: rtl/sic_pkg.sv
package sic_pkg;
   typedef enum logic [1:0] {
      WS_INV = 2'b00,
      WS_VAL = 2'b01,
      WS_REG = 2'b10
   } wstate_e;
endpackage

// File: rtl/sic_word_store.sv
module sic_word_store
   import sic_pkg::*;
#(
   parameter int NWORDS   = 64,
   parameter int DATA_W   = 32,
   parameter int REGION_W = 3,
   parameter int IDX_W    = 6,
   parameter int NREG     = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [IDX_W-1:0]    rd_idx,
   output wstate_e             rd_state,
   output logic [DATA_W-1:0]   rd_data,
   output logic                rd_touched,
   output logic                rd_pend,
   input  logic                wr_en,
   input  logic [IDX_W-1:0]    wr_idx,
   input  wstate_e             wr_state,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic [REGION_W-1:0] wr_region,
   input  logic                kill_en,
   input  logic [IDX_W-1:0]    kill_idx,
   input  logic                touch_set,
   input  logic [IDX_W-1:0]    touch_idx,
   input  logic                touch_clr_all,
   input  logic                pend_set,
   input  logic [IDX_W-1:0]    pend_idx,
   input  logic                ack_en,
   input  logic [IDX_W-1:0]    ack_idx,
   input  logic                bulk_en,
   input  logic [NREG-1:0]     bulk_mask
);

   wstate_e             st_arr [NWORDS];
   logic [DATA_W-1:0]   dt_arr [NWORDS];
   logic                tc_arr [NWORDS];
   logic                pn_arr [NWORDS];

   for (genvar i = 0; i < NWORDS; i++) begin : g_word
      localparam logic [IDX_W-1:0] MY = IDX_W'(i);
      wstate_e             st_q;
      logic [DATA_W-1:0]   dt_q;
      logic [REGION_W-1:0] rg_q;
      logic                tc_q;
      logic                pn_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_q <= WS_INV;
            dt_q <= '0;
            rg_q <= '0;
            tc_q <= 1'b0;
            pn_q <= 1'b0;
         end else begin
            if (bulk_en && st_q == WS_VAL && bulk_mask[rg_q]) st_q <= WS_INV;
            if (kill_en && kill_idx == MY && st_q == WS_VAL)  st_q <= WS_INV;
            if (wr_en && wr_idx == MY) begin
               st_q <= wr_state;
               dt_q <= wr_data;
               rg_q <= wr_region;
            end
            if (touch_clr_all)                 tc_q <= 1'b0;
            if (touch_set && touch_idx == MY)  tc_q <= 1'b1;
            if (ack_en && ack_idx == MY)       pn_q <= 1'b0;
            if (pend_set && pend_idx == MY)    pn_q <= 1'b1;
         end
      end

      assign st_arr[i] = st_q;
      assign dt_arr[i] = dt_q;
      assign tc_arr[i] = tc_q;
      assign pn_arr[i] = pn_q;

      AST_LEGAL_STATE: assert property (@(posedge clk) disable iff (!rst_n)
         st_q inside {WS_INV, WS_VAL, WS_REG}); // R1
      AST_REG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
         (st_q == WS_REG && !(wr_en && wr_idx == MY)) |=> (st_q == WS_REG)); // R4
      AST_TOUCH_CLR: assert property (@(posedge clk) disable iff (!rst_n)
         (touch_clr_all && !(touch_set && touch_idx == MY)) |=> !tc_q); // R9
   end

   assign rd_state   = st_arr[rd_idx];
   assign rd_data    = dt_arr[rd_idx];
   assign rd_touched = tc_arr[rd_idx];
   assign rd_pend    = pn_arr[rd_idx];

endmodule

// File: rtl/sic_req_ctrl.sv
module sic_req_ctrl
   import sic_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int REGION_W = 3,
   parameter int IDX_W    = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_store,
   input  logic                req_atomic,
   input  logic [IDX_W-1:0]    req_idx,
   input  logic [REGION_W-1:0] req_region,
   input  logic [DATA_W-1:0]   req_wdata,
   input  logic                sig_hit,
   output logic                req_ready,
   output logic                rsp_valid,
   output logic [DATA_W-1:0]   rsp_rdata,
   output logic                miss_valid,
   output logic [IDX_W-1:0]    miss_idx,
   input  logic                fill_valid,
   input  logic [DATA_W-1:0]   fill_data,
   output logic                reg_valid,
   output logic [IDX_W-1:0]    reg_idx,
   input  logic                phase_end,
   input  logic                cs_enter,
   input  wstate_e             rd_state,
   input  logic [DATA_W-1:0]   rd_data,
   input  logic                rd_touched,
   input  logic                rd_pend,
   output logic                wr_en,
   output logic [IDX_W-1:0]    wr_idx,
   output wstate_e             wr_state,
   output logic [DATA_W-1:0]   wr_data,
   output logic [REGION_W-1:0] wr_region,
   output logic                kill_en,
   output logic                touch_set,
   output logic [IDX_W-1:0]    touch_idx,
   output logic                pend_set
);

   typedef enum logic {C_IDLE, C_WAIT} ctl_e;

   ctl_e                cs_q;
   logic [IDX_W-1:0]    wait_idx_q;
   logic [REGION_W-1:0] wait_rg_q;
   logic                wait_at_q;
   logic                accept;
   logic                self_inv;
   logic                load_hit;

   assign req_ready = (cs_q == C_IDLE) && !phase_end && !cs_enter;
   assign accept    = req_valid && req_ready;
   assign self_inv  = req_atomic && (rd_state == WS_VAL) && !rd_touched && sig_hit;
   assign load_hit  = (rd_state != WS_INV) && !self_inv;

   always_comb begin
      wr_en     = 1'b0;
      wr_idx    = req_idx;
      wr_state  = WS_REG;
      wr_data   = req_wdata;
      wr_region = req_region;
      kill_en   = 1'b0;
      touch_set = 1'b0;
      touch_idx = req_idx;
      pend_set  = 1'b0;
      if (accept && req_store) begin
         wr_en    = 1'b1;
         pend_set = !rd_pend;
      end else if (accept) begin
         if (load_hit) touch_set = req_atomic;
         else          kill_en   = self_inv;
      end else if (cs_q == C_WAIT && fill_valid) begin
         wr_en     = 1'b1;
         wr_idx    = wait_idx_q;
         wr_state  = WS_VAL;
         wr_data   = fill_data;
         wr_region = wait_rg_q;
         touch_set = wait_at_q;
         touch_idx = wait_idx_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cs_q       <= C_IDLE;
         rsp_valid  <= 1'b0;
         rsp_rdata  <= '0;
         miss_valid <= 1'b0;
         miss_idx   <= '0;
         reg_valid  <= 1'b0;
         reg_idx    <= '0;
         wait_idx_q <= '0;
         wait_rg_q  <= '0;
         wait_at_q  <= 1'b0;
      end else begin
         rsp_valid  <= 1'b0;
         miss_valid <= 1'b0;
         reg_valid  <= 1'b0;
         case (cs_q)
            C_IDLE: begin
               if (accept && req_store) begin
                  rsp_valid <= 1'b1;
                  rsp_rdata <= req_wdata;
                  if (!rd_pend) begin
                     reg_valid <= 1'b1;
                     reg_idx   <= req_idx;
                  end
               end else if (accept && load_hit) begin
                  rsp_valid <= 1'b1;
                  rsp_rdata <= rd_data;
               end else if (accept) begin
                  miss_valid <= 1'b1;
                  miss_idx   <= req_idx;
                  wait_idx_q <= req_idx;
                  wait_rg_q  <= req_region;
                  wait_at_q  <= req_atomic;
                  cs_q       <= C_WAIT;
               end
            end
            default: begin
               if (fill_valid) begin
                  rsp_valid <= 1'b1;
                  rsp_rdata <= fill_data;
                  cs_q      <= C_IDLE;
               end
            end
         endcase
      end
   end

   AST_STORE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && req_store) |=> (rsp_valid && rsp_rdata == $past(req_wdata))); // R2
   AST_PEND_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && req_store && rd_pend) |=> !reg_valid); // R10
   AST_MISS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      miss_valid |-> (!req_ready && !rsp_valid)); // R5
   AST_MISS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      miss_valid |=> !miss_valid); // R5
   AST_TOUCHED_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !req_store && req_atomic && rd_touched && rd_state != WS_INV)
      |=> (rsp_valid && !miss_valid)); // R8

endmodule

// File: rtl/sicache_word_ctrl.sv
module sicache_word_ctrl
   import sic_pkg::*;
#(
   parameter int  NWORDS   = 64,
   parameter int  DATA_W   = 32,
   parameter int  REGION_W = 3,
   localparam int IDX_W    = $clog2(NWORDS),
   localparam int NREG     = 1 << REGION_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_store,
   input  logic                req_atomic,
   input  logic [IDX_W-1:0]    req_addr,
   input  logic [REGION_W-1:0] req_region,
   input  logic [DATA_W-1:0]   req_wdata,
   input  logic                sig_hit,
   output logic                req_ready,
   output logic                rsp_valid,
   output logic [DATA_W-1:0]   rsp_rdata,
   output logic                miss_valid,
   output logic [IDX_W-1:0]    miss_addr,
   input  logic                fill_valid,
   input  logic [DATA_W-1:0]   fill_data,
   output logic                reg_valid,
   output logic [IDX_W-1:0]    reg_addr,
   input  logic                reg_ack_valid,
   input  logic [IDX_W-1:0]    reg_ack_addr,
   input  logic                phase_end,
   input  logic [NREG-1:0]     phase_regions,
   input  logic                cs_enter
);

   if (NWORDS < 2 || (NWORDS & (NWORDS - 1)) != 0) begin : g_bad_depth
      $error("NWORDS must be a power of two of at least 2");
   end
   if (DATA_W < 1 || REGION_W < 1 || REGION_W > 8) begin : g_bad_width
      $error("DATA_W must be positive and REGION_W in 1..8");
   end

   wstate_e             rd_state;
   logic [DATA_W-1:0]   rd_data;
   logic                rd_touched;
   logic                rd_pend;
   logic                wr_en;
   logic [IDX_W-1:0]    wr_idx;
   wstate_e             wr_state;
   logic [DATA_W-1:0]   wr_data;
   logic [REGION_W-1:0] wr_region;
   logic                kill_en;
   logic                touch_set;
   logic [IDX_W-1:0]    touch_idx;
   logic                pend_set;

   sic_req_ctrl #(
      .DATA_W(DATA_W), .REGION_W(REGION_W), .IDX_W(IDX_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_store(req_store), .req_atomic(req_atomic),
      .req_idx(req_addr), .req_region(req_region), .req_wdata(req_wdata),
      .sig_hit(sig_hit), .req_ready(req_ready),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .miss_valid(miss_valid), .miss_idx(miss_addr),
      .fill_valid(fill_valid), .fill_data(fill_data),
      .reg_valid(reg_valid), .reg_idx(reg_addr),
      .phase_end(phase_end), .cs_enter(cs_enter),
      .rd_state(rd_state), .rd_data(rd_data), .rd_touched(rd_touched), .rd_pend(rd_pend),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_state(wr_state), .wr_data(wr_data),
      .wr_region(wr_region), .kill_en(kill_en),
      .touch_set(touch_set), .touch_idx(touch_idx), .pend_set(pend_set)
   );

   sic_word_store #(
      .NWORDS(NWORDS), .DATA_W(DATA_W), .REGION_W(REGION_W),
      .IDX_W(IDX_W), .NREG(NREG)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(req_addr), .rd_state(rd_state), .rd_data(rd_data),
      .rd_touched(rd_touched), .rd_pend(rd_pend),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_state(wr_state), .wr_data(wr_data),
      .wr_region(wr_region),
      .kill_en(kill_en), .kill_idx(req_addr),
      .touch_set(touch_set), .touch_idx(touch_idx), .touch_clr_all(cs_enter),
      .pend_set(pend_set), .pend_idx(req_addr),
      .ack_en(reg_ack_valid), .ack_idx(reg_ack_addr),
      .bulk_en(phase_end), .bulk_mask(phase_regions)
   );

endmodule

// File: tb/tb_sicache_word_ctrl.sv
module tb_sicache_word_ctrl;
   localparam int NW = 64;
   localparam int DW = 32;
   localparam int RW = 3;
   localparam int AW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_store = 1'b0, req_atomic = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [RW-1:0] req_region = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          sig_hit = 1'b0;
   logic          req_ready, rsp_valid, miss_valid, reg_valid;
   logic [DW-1:0] rsp_rdata;
   logic [AW-1:0] miss_addr, reg_addr;
   logic          fill_valid = 1'b0;
   logic [DW-1:0] fill_data = '0;
   logic          reg_ack_valid = 1'b0;
   logic [AW-1:0] reg_ack_addr = '0;
   logic          phase_end = 1'b0;
   logic [7:0]    phase_regions = '0;
   logic          cs_enter = 1'b0;

   sicache_word_ctrl #(.NWORDS(NW), .DATA_W(DW), .REGION_W(RW)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
      .req_atomic(req_atomic), .req_addr(req_addr), .req_region(req_region),
      .req_wdata(req_wdata), .sig_hit(sig_hit), .req_ready(req_ready),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .miss_valid(miss_valid),
      .miss_addr(miss_addr), .fill_valid(fill_valid), .fill_data(fill_data),
      .reg_valid(reg_valid), .reg_addr(reg_addr), .reg_ack_valid(reg_ack_valid),
      .reg_ack_addr(reg_ack_addr), .phase_end(phase_end),
      .phase_regions(phase_regions), .cs_enter(cs_enter));

   always #4 clk = ~clk;

   // model: 0 Invalid, 1 Valid, 2 Registered
   int            m_st [NW];
   logic [DW-1:0] m_dt [NW];
   logic [RW-1:0] m_rg [NW];
   bit            m_tc [NW];
   bit            m_pn [NW];
   int            n_chk = 0;
   int            n_bad = 0;
   bit            done = 1'b0;

   task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
      end
   endtask

   function automatic bit exp_self_inv(int a, bit at, bit sh);
      return at && m_st[a] == 1 && !m_tc[a] && sh;
   endfunction

   task automatic do_req(bit st, bit at, int a, logic [RW-1:0] rg, logic [DW-1:0] wd,
                         bit sh, string why);
      bit            si, hit, exp_reg;
      logic [DW-1:0] fd;
      int            k;
      @(negedge clk);
      chk(why, "ready before request", req_ready, 1);
      req_valid = 1; req_store = st; req_atomic = at; req_addr = AW'(a);
      req_region = rg; req_wdata = wd; sig_hit = sh;
      @(negedge clk);
      req_valid = 0; sig_hit = 0;
      if (st) begin
         exp_reg = !m_pn[a];
         chk({why, "/R2"}, "store rsp_valid", rsp_valid, 1);
         chk({why, "/R2"}, "store rsp_rdata", rsp_rdata, wd);
         chk({why, "/R10"}, "reg_valid", reg_valid, exp_reg);
         if (exp_reg) chk({why, "/R2"}, "reg_addr", reg_addr, a);
         chk({why, "/R2"}, "no miss on store", miss_valid, 0);
         m_st[a] = 2; m_dt[a] = wd; m_rg[a] = rg; m_pn[a] = 1;
      end else begin
         si  = exp_self_inv(a, at, sh);
         hit = (m_st[a] != 0) && !si;
         if (hit) begin
            chk({why, "/R6"}, "hit rsp_valid", rsp_valid, 1);
            chk({why, "/R6"}, "hit data", rsp_rdata, m_dt[a]);
            chk({why, "/R6"}, "hit no miss", miss_valid, 0);
            if (at) m_tc[a] = 1;
         end else begin
            chk({why, si ? "/R7" : "/R5"}, "miss_valid", miss_valid, 1);
            chk({why, "/R5"}, "miss_addr", miss_addr, a);
            chk({why, "/R5"}, "no rsp on miss", rsp_valid, 0);
            k = $urandom_range(0, 3);
            for (int j = 0; j < k; j++) begin
               @(negedge clk);
               chk({why, "/R5"}, "stall ready", req_ready, 0);
               chk({why, "/R5"}, "stall rsp", rsp_valid, 0);
            end
            fd = $urandom;
            fill_valid = 1; fill_data = fd;
            @(negedge clk);
            fill_valid = 0;
            chk({why, "/R5"}, "fill rsp_valid", rsp_valid, 1);
            chk({why, "/R5"}, "fill data", rsp_rdata, fd);
            m_st[a] = 1; m_dt[a] = fd; m_rg[a] = rg;
            if (at) m_tc[a] = 1;
         end
      end
   endtask

   task automatic do_phase(logic [7:0] mask);
      @(negedge clk);
      phase_end = 1; phase_regions = mask;
      #1 chk("R11", "ready during phase_end", req_ready, 0);
      @(negedge clk);
      phase_end = 0;
      for (int i = 0; i < NW; i++)
         if (m_st[i] == 1 && mask[m_rg[i]]) m_st[i] = 0;
   endtask

   task automatic do_cs();
      @(negedge clk);
      cs_enter = 1;
      #1 chk("R11", "ready during cs_enter", req_ready, 0);
      @(negedge clk);
      cs_enter = 0;
      for (int i = 0; i < NW; i++) m_tc[i] = 0;
   endtask

   task automatic do_ack(int a);
      @(negedge clk);
      reg_ack_valid = 1; reg_ack_addr = AW'(a);
      @(negedge clk);
      reg_ack_valid = 0;
      m_pn[a] = 0;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      int op;
      void'($urandom(32'h5EED));
      for (int i = 0; i < NW; i++) begin
         m_st[i] = 0; m_dt[i] = '0; m_rg[i] = '0; m_tc[i] = 0; m_pn[i] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1", "reset ready", req_ready, 1);
      chk("R1", "reset rsp_valid", rsp_valid, 0);
      chk("R1", "reset miss_valid", miss_valid, 0);
      chk("R1", "reset reg_valid", reg_valid, 0);

      // directed corner cases
      do_req(0, 0, 5, 3'd1, '0, 0, "R1 first load misses");
      do_req(0, 0, 5, 3'd1, '0, 0, "R6 reload hits");
      do_req(1, 0, 9, 3'd1, 32'hA5A5_0001, 0, "R2 store");
      do_req(1, 0, 9, 3'd1, 32'hA5A5_0002, 0, "R10 store while pending");
      do_ack(9);
      do_req(1, 0, 9, 3'd1, 32'hA5A5_0003, 0, "R10 store after ack");
      do_phase(8'hFF);
      do_req(0, 0, 5, 3'd1, '0, 0, "R3 valid word dropped");
      do_req(0, 0, 9, 3'd1, '0, 0, "R4 registered word kept");
      do_req(0, 0, 12, 3'd2, '0, 0, "R3 setup");
      do_req(0, 0, 13, 3'd3, '0, 0, "R3 setup");
      do_phase(8'b0000_0100);
      do_req(0, 0, 12, 3'd2, '0, 0, "R3 masked region misses");
      do_req(0, 0, 13, 3'd3, '0, 0, "R3 other region hits");
      do_cs();
      do_req(0, 1, 13, 3'd3, '0, 1, "R7 atomic sig hit self-invalidates");
      do_req(0, 1, 13, 3'd3, '0, 1, "R8 touched word hits");
      do_req(0, 0, 12, 3'd2, '0, 1, "R7 plain load ignores sig");
      do_req(0, 1, 12, 3'd2, '0, 0, "R7 atomic without sig hits");
      do_cs();
      do_req(0, 1, 12, 3'd2, '0, 1, "R9 touch cleared by entry");
      do_req(0, 1, 9, 3'd1, '0, 1, "R4 registered atomic hit");

      // constrained random mix on a small address window
      for (int n = 0; n < 3000; n++) begin
         op = $urandom_range(0, 99);
         if (op < 55)
            do_req(0, 1'($urandom_range(0, 1)), $urandom_range(0, 15),
                   3'($urandom_range(0, 7)), '0, 1'($urandom_range(0, 1)), "rnd load");
         else if (op < 80)
            do_req(1, 1'($urandom_range(0, 1)), $urandom_range(0, 15),
                   3'($urandom_range(0, 7)), $urandom, 0, "rnd store");
         else if (op < 88)
            do_ack($urandom_range(0, 15));
         else if (op < 94)
            do_phase(8'($urandom));
         else
            do_cs();
      end
      done = 1;
      finish_run();
   end
endmodule